// File: doc/BRIEF.md
# Four-Level Program Counter Stack

This block holds the program counter state of a small 4-bit processor. Four 12-bit counters sit in a bank, and a 2-bit level pointer picks the counter that is active. A subroutine call moves the pointer up by one and starts the new counter at the call target. A return moves the pointer back down. Three nested subroutine levels are therefore possible. The pointer wraps silently in both directions, so a fourth nested call overwrites the outermost counter.

The instruction decoder presents one operation per instruction step. The operations are hold, advance, full jump, call, return, conditional in-page jump, increment-and-skip, and indirect in-page jump. It supplies the operand nibble, the 12-bit target (the low byte also carries a register pair value), a 4-bit condition code and the status flags with them. An in-page jump keeps the page, meaning the upper 4 bits, of the address that follows the instruction, and replaces the low 8 bits. On a return the block also issues a write strobe and a nibble for the accumulator. Memory, the register file and instruction decode live elsewhere.

Top module: `nest_pc_stack`

## Requirements
- R1: While rst_n is low, and after it is released, the level is 0 and every counter is 0, so pc_o reads 0x000.
- R2: op_i = 1 (advance) adds 1 to the active counter, wrapping from 0xFFF to 0x000. op_i = 0 (hold) leaves pc_o and level_o unchanged.
- R3: op_i = 2 (jump) loads tgt_i into the active counter at the next edge and leaves the level unchanged.
- R4: op_i = 3 (call) first sets the caller's counter to its value plus 2. It then raises the level by 1 and loads tgt_i into the newly selected counter. A later return therefore resumes past both bytes of the call.
- R5: op_i = 4 (return) lowers the level by 1, and pc_o becomes the value held by that level's counter. During a return step acc_we_o is 1 and acc_data_o equals nib_i. In all other steps acc_we_o is 0.
- R6: The level wraps modulo 4: a call from level 3 goes to level 0, and a return from level 0 goes to level 3. No other signal reports this.
- R7: op_i = 5 (conditional) evaluates the tests selected by cond_i. Bit 0 selects "test_i is low", bit 1 selects "carry_i is 1" and bit 2 selects "acc_zero_i is 1". With bit 3 clear, the jump is taken if any selected test is true. With bit 3 set, the jump is taken only if no selected test is true. Code 4'b1000 therefore always jumps and code 4'b0000 never jumps.
- R8: A taken conditional jump sets pc_o to {upper 4 bits of (pc + 2), tgt_i[7:0]}. A jump that is not taken sets pc_o to pc + 2.
- R9: op_i = 6 (increment-and-skip) jumps when (nib_i + 1) mod 16 is nonzero, using the same target and fall-through rule as R8. When nib_i = 15 it falls through to pc + 2.
- R10: op_i = 7 (indirect) sets pc_o to {upper 4 bits of (pc + 1), tgt_i[7:0]}, where tgt_i[7:0] holds the register pair value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Operation code (0 hold, 1 advance, 2 jump, 3 call, 4 return, 5 conditional, 6 increment-and-skip, 7 indirect) |
| tgt_i | input | 12 | Jump or call target; the low byte is the in-page target or register pair value |
| cond_i | input | 4 | Condition code for the conditional jump |
| nib_i | input | 4 | Register nibble for increment-and-skip, or the immediate for a return |
| acc_zero_i | input | 1 | Accumulator equals zero |
| carry_i | input | 1 | Carry flag |
| test_i | input | 1 | Test pin; a low level counts as true |
| pc_o | output | 12 | Active program counter |
| level_o | output | 2 | Active stack level |
| acc_we_o | output | 1 | Accumulator write strobe during a return |
| acc_data_o | output | 4 | Accumulator write data during a return |

## Verification
The assertions check, on every cycle, the single-step effects of each operation. These are the advance and hold updates, the full jump, the level moving by one on calls and returns, the page kept on conditional and indirect jumps, the fixed outcome of codes 4'b1000 and 4'b0000, and the fall-through when nib_i is 15. Several effects only show across many steps, and the directed scenarios cover them. One is the return address being the call address plus 2. Another is a fourth nested call overwriting the outermost counter, which then returns to the wrong place. The bench also sweeps all sixteen condition codes against every flag combination and checks jumps that cross a page boundary.

// File: rtl/nest_pc_pkg.sv
package nest_pc_pkg;

    parameter int PC_W_DEF  = 12;
    parameter int PAGE_W_DEF = 8;
    parameter int LVL_DEF   = 4;
    parameter int NIB_W_DEF = 4;

    // condition code bit positions
    localparam int CB_TEST = 0;
    localparam int CB_CARRY = 1;
    localparam int CB_ZERO = 2;
    localparam int CB_INV  = 3;

    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_NEXT  = 3'd1,
        OP_JUMP  = 3'd2,
        OP_CALL  = 3'd3,
        OP_RET   = 3'd4,
        OP_COND  = 3'd5,
        OP_ISZ   = 3'd6,
        OP_INDIR = 3'd7
    } pc_op_e;

endpackage

// File: rtl/nest_cond_judge.sv
module nest_cond_judge
    import nest_pc_pkg::*;
(
    input  logic [3:0] cond_i,
    input  logic       acc_zero_i,
    input  logic       carry_i,
    input  logic       test_i,
    output logic       take_o
);
    logic any_hit;

    always_comb begin
        any_hit = (cond_i[CB_TEST]  & ~test_i)
                | (cond_i[CB_CARRY] & carry_i)
                | (cond_i[CB_ZERO]  & acc_zero_i);
        take_o  = cond_i[CB_INV] ? ~any_hit : any_hit;
    end

endmodule

// File: rtl/nest_pc_bank.sv
module nest_pc_bank #(
    parameter int PC_W  = 12,
    parameter int LVL   = 4,
    localparam int LVL_W = $clog2(LVL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] ptr_d,
    input  logic             wa_en,
    input  logic [LVL_W-1:0] wa_idx,
    input  logic [PC_W-1:0]  wa_val,
    input  logic             wb_en,
    input  logic [LVL_W-1:0] wb_idx,
    input  logic [PC_W-1:0]  wb_val,
    output logic [LVL_W-1:0] ptr_q,
    output logic [PC_W-1:0]  pc_o
);
    logic [PC_W-1:0] cnt_d [LVL];
    logic [PC_W-1:0] cnt_q [LVL];

    generate
        for (genvar g = 0; g < LVL; g++) begin : g_lvl
            always_comb begin
                cnt_d[g] = cnt_q[g];
                if (wb_en && wb_idx == LVL_W'(g))
                    cnt_d[g] = wb_val;
                else if (wa_en && wa_idx == LVL_W'(g))
                    cnt_d[g] = wa_val;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) cnt_q[g] <= '0;
                else        cnt_q[g] <= cnt_d[g];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign pc_o = cnt_q[ptr_q];

endmodule

// File: rtl/nest_pc_stack.sv
module nest_pc_stack
    import nest_pc_pkg::*;
#(
    parameter int PC_W   = PC_W_DEF,
    parameter int PAGE_W = PAGE_W_DEF,
    parameter int LVL    = LVL_DEF,
    parameter int NIB_W  = NIB_W_DEF,
    localparam int LVL_W = $clog2(LVL),
    localparam int HI_W  = PC_W - PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic [PC_W-1:0]   tgt_i,
    input  logic [3:0]        cond_i,
    input  logic [NIB_W-1:0]  nib_i,
    input  logic              acc_zero_i,
    input  logic              carry_i,
    input  logic              test_i,
    output logic [PC_W-1:0]   pc_o,
    output logic [LVL_W-1:0]  level_o,
    output logic              acc_we_o,
    output logic [NIB_W-1:0]  acc_data_o
);
    typedef struct packed {
        logic [LVL_W-1:0] ptr;
        logic             wa_en;
        logic [LVL_W-1:0] wa_idx;
        logic [PC_W-1:0]  wa_val;
        logic             wb_en;
        logic [LVL_W-1:0] wb_idx;
        logic [PC_W-1:0]  wb_val;
    } nxt_t;

    pc_op_e           op;
    nxt_t             nxt_d;
    logic [LVL_W-1:0] ptr_q;
    logic [PC_W-1:0]  pc_q;
    logic [PC_W-1:0]  pc_p1;
    logic [PC_W-1:0]  pc_p2;
    logic [PC_W-1:0]  page_tgt2;
    logic [PC_W-1:0]  page_tgt1;
    logic [NIB_W-1:0] nib_inc;
    logic             cond_take;

    assign op = pc_op_e'(op_i);

    nest_cond_judge u_judge (
        .cond_i    (cond_i),
        .acc_zero_i(acc_zero_i),
        .carry_i   (carry_i),
        .test_i    (test_i),
        .take_o    (cond_take)
    );

    always_comb begin
        pc_p1     = pc_q + PC_W'(1);
        pc_p2     = pc_q + PC_W'(2);
        page_tgt2 = {pc_p2[PC_W-1 -: HI_W], tgt_i[PAGE_W-1:0]};
        page_tgt1 = {pc_p1[PC_W-1 -: HI_W], tgt_i[PAGE_W-1:0]};
        nib_inc   = nib_i + NIB_W'(1);

        nxt_d        = '0;
        nxt_d.ptr    = ptr_q;
        nxt_d.wa_idx = ptr_q;
        nxt_d.wb_idx = ptr_q + LVL_W'(1);
        unique case (op)
            OP_HOLD: ;
            OP_NEXT: begin
                nxt_d.wa_en  = 1'b1;
                nxt_d.wa_val = pc_p1;
            end
            OP_JUMP: begin
                nxt_d.wa_en  = 1'b1;
                nxt_d.wa_val = tgt_i;
            end
            OP_CALL: begin
                nxt_d.wa_en  = 1'b1;
                nxt_d.wa_val = pc_p2;
                nxt_d.wb_en  = 1'b1;
                nxt_d.wb_val = tgt_i;
                nxt_d.ptr    = ptr_q + LVL_W'(1);
            end
            OP_RET: begin
                nxt_d.ptr    = ptr_q - LVL_W'(1);
            end
            OP_COND: begin
                nxt_d.wa_en  = 1'b1;
                nxt_d.wa_val = cond_take ? page_tgt2 : pc_p2;
            end
            OP_ISZ: begin
                nxt_d.wa_en  = 1'b1;
                nxt_d.wa_val = (nib_inc != '0) ? page_tgt2 : pc_p2;
            end
            OP_INDIR: begin
                nxt_d.wa_en  = 1'b1;
                nxt_d.wa_val = page_tgt1;
            end
            default: ;
        endcase
    end

    nest_pc_bank #(
        .PC_W(PC_W),
        .LVL (LVL)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .ptr_d (nxt_d.ptr),
        .wa_en (nxt_d.wa_en),
        .wa_idx(nxt_d.wa_idx),
        .wa_val(nxt_d.wa_val),
        .wb_en (nxt_d.wb_en),
        .wb_idx(nxt_d.wb_idx),
        .wb_val(nxt_d.wb_val),
        .ptr_q (ptr_q),
        .pc_o  (pc_q)
    );

    assign pc_o       = pc_q;
    assign level_o    = ptr_q;
    assign acc_we_o   = (op == OP_RET);
    assign acc_data_o = nib_i;

    // ---------------- assertions ----------------
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 3'd1 |=> pc_o == $past(pc_o) + PC_W'(1));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 3'd0 |=> $stable(pc_o) && $stable(level_o));

    p_jump_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 3'd2 |=> pc_o == $past(tgt_i) && $stable(level_o));

    p_call_lvl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 3'd3 |=> level_o == $past(level_o) + LVL_W'(1) && pc_o == $past(tgt_i));

    p_ret_lvl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 3'd4 |=> level_o == $past(level_o) - LVL_W'(1));

    p_always_r7: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 3'd5 && cond_i == 4'b1000 |=>
            pc_o[PAGE_W-1:0] == $past(tgt_i[PAGE_W-1:0]));

    p_never_r7: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 3'd5 && cond_i == 4'b0000 |=> pc_o == $past(pc_o) + PC_W'(2));

    p_page_r8: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 3'd5 |=> pc_o[PC_W-1 -: HI_W] == $past(pc_p2[PC_W-1 -: HI_W]));

    p_isz_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 3'd6 && nib_i == '1 |=> pc_o == $past(pc_o) + PC_W'(2));

    p_indir_r10: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 3'd7 |=> pc_o[PC_W-1 -: HI_W] == $past(pc_p1[PC_W-1 -: HI_W])
                      && pc_o[PAGE_W-1:0] == $past(tgt_i[PAGE_W-1:0]));

endmodule

// File: tb/nest_pc_stack_test.sv
module nest_pc_stack_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [11:0] tgt_i = '0;
    logic [3:0]  cond_i = '0;
    logic [3:0]  nib_i = '0;
    logic        acc_zero_i = 1'b0;
    logic        carry_i = 1'b0;
    logic        test_i = 1'b1;
    logic [11:0] pc_o;
    logic [1:0]  level_o;
    logic        acc_we_o;
    logic [3:0]  acc_data_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    nest_pc_stack uut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .tgt_i(tgt_i), .cond_i(cond_i),
        .nib_i(nib_i), .acc_zero_i(acc_zero_i), .carry_i(carry_i), .test_i(test_i),
        .pc_o(pc_o), .level_o(level_o), .acc_we_o(acc_we_o), .acc_data_o(acc_data_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // one instruction step: drive at negedge, sample 1 ns after the edge
    task automatic step(input logic [2:0] o, input logic [11:0] t,
                        input logic [3:0] c = 4'd0, input logic [3:0] n = 4'd0,
                        input logic az = 1'b0, input logic cy = 1'b0,
                        input logic ts = 1'b1);
        @(negedge clk);
        op_i = o; tgt_i = t; cond_i = c; nib_i = n;
        acc_zero_i = az; carry_i = cy; test_i = ts;
        @(posedge clk);
        #1;
        op_i = 3'd0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 pc in reset", pc_o, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 pc after reset", pc_o, 0);
        chk("R1 level after reset", level_o, 0);
        chk("R5 no acc write when idle", acc_we_o, 0);
    endtask

    task automatic t_advance();
        step(3'd1, 0); step(3'd1, 0); step(3'd1, 0);
        chk("R2 advance x3", pc_o, 3);
        step(3'd0, 12'hABC);
        chk("R2 hold pc", pc_o, 3);
        chk("R2 hold level", level_o, 0);
    endtask

    task automatic t_jump();
        step(3'd2, 12'hFFF);
        chk("R3 full jump", pc_o, 12'hFFF);
        chk("R3 level kept", level_o, 0);
        step(3'd1, 0);
        chk("R2 wrap at 12 bits", pc_o, 0);
    endtask

    task automatic t_call_ret();
        step(3'd2, 12'h120);
        step(3'd3, 12'h3A5);
        chk("R4 call level", level_o, 1);
        chk("R4 call target", pc_o, 12'h3A5);
        step(3'd1, 0);
        chk("R4 callee advances", pc_o, 12'h3A6);
        @(negedge clk);
        op_i = 3'd4; nib_i = 4'h9;
        #1;
        chk("R5 acc strobe on return", acc_we_o, 1);
        chk("R5 acc data on return", acc_data_o, 9);
        @(posedge clk); #1;
        op_i = 3'd0;
        chk("R5 return level", level_o, 0);
        chk("R4 return address past call", pc_o, 12'h122);
    endtask

    task automatic t_wrap();
        step(3'd3, 12'h200);
        step(3'd3, 12'h300);
        step(3'd3, 12'h400);
        chk("R6 level 3", level_o, 3);
        step(3'd3, 12'h500);
        chk("R6 call wraps level", level_o, 0);
        chk("R6 overwrite outer counter", pc_o, 12'h500);
        step(3'd4, 0);
        chk("R6 ret to level 3", pc_o, 12'h402);
        step(3'd4, 0);
        chk("R5 ret to level 2", pc_o, 12'h302);
        step(3'd4, 0);
        chk("R5 ret to level 1", pc_o, 12'h202);
        step(3'd4, 0);
        chk("R6 outer counter lost", pc_o, 12'h500);
        chk("R6 level 0", level_o, 0);
        step(3'd4, 0);
        chk("R6 return underflow level", level_o, 3);
        chk("R6 return underflow pc", pc_o, 12'h402);
    endtask

    task automatic t_cond();
        step(3'd2, 12'h0FE);
        step(3'd5, 12'h034, 4'b1000);
        chk("R8 page from pc+2 crossing", pc_o, 12'h134);
        step(3'd2, 12'h200);
        step(3'd5, 12'h0FF, 4'b0000, 0, 1'b1, 1'b1, 1'b0);
        chk("R7 code 0000 never", pc_o, 12'h202);
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 8; f++) begin
                logic az, cy, ts, any, take;
                az = f[0]; cy = f[1]; ts = f[2];
                any  = (c[0] & ~ts) | (c[1] & cy) | (c[2] & az);
                take = c[3] ? ~any : any;
                step(3'd2, 12'h250);
                step(3'd5, 12'hE10, 4'(c), 0, az, cy, ts);
                chk($sformatf("R7 code %0d flags %0d", c, f), pc_o,
                    take ? 12'h210 : 12'h252);
            end
        end
    endtask

    task automatic t_isz();
        step(3'd2, 12'h3F0);
        step(3'd6, 12'h080, 0, 4'd5);
        chk("R9 nonzero jumps", pc_o, 12'h380);
        step(3'd2, 12'h3F0);
        step(3'd6, 12'h080, 0, 4'd15);
        chk("R9 zero falls through", pc_o, 12'h3F2);
        step(3'd2, 12'h4FF);
        step(3'd6, 12'h011, 0, 4'd0);
        chk("R9 page from pc+2", pc_o, 12'h511);
    endtask

    task automatic t_indir();
        step(3'd2, 12'h6FF);
        step(3'd7, 12'h042);
        chk("R10 page from pc+1", pc_o, 12'h742);
        step(3'd2, 12'h610);
        step(3'd7, 12'hFAB);
        chk("R10 same page", pc_o, 12'h6AB);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_advance();
        t_jump();
        t_call_ret();
        t_wrap();
        t_cond();
        t_isz();
        t_indir();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule